// File: doc/BRIEF.md
# Addressable LED Three-Slot Bit Encoder

This block drives the data input of a chain of single-wire RGB LEDs. It takes one 24-bit colour word per LED and serialises it onto one output line. Every colour bit is sent as a symbol of three equal time slots. A one is two high slots followed by one low slot. A zero is one high slot followed by two low slots. The slot length is a whole number of system clocks, set by a divider parameter. With a 72 MHz clock and a ratio of 32, a slot is about 444 ns, so a one is high for about 888 ns and a zero for about 444 ns.

Colour words arrive on a valid/ready handshake, each with a flag that marks the last LED of a frame. The symbols of consecutive LEDs follow each other with no gap. Each LED takes exactly 72 slots, which is 9 bytes of encoded data.

After the LED flagged as last, the block holds the line low for a parameterised latch interval, 120 slots by default (about 53 µs), and then drops its busy flag. If the next word is not offered in time, the block treats this as an underrun and ends the frame the same way.

The input word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The order in which the channels go onto the wire is a parameter.

Top module: `ledenc_top`

## Requirements
- R1: A colour bit of 1 is driven high for 2*DIV clocks, then low for DIV clocks (slot pattern PAT_ONE = 3'b110, first slot in bit 2).
- R2: A colour bit of 0 is driven high for DIV clocks, then low for 2*DIV clocks (slot pattern PAT_ZERO = 3'b100).
- R3: Every slot lasts exactly DIV system clocks, so one symbol lasts 3*DIV clocks.
- R4: With CHAN_ORDER = 0, the wire order is green (inData[15:8]), then red (inData[23:16]), then blue (inData[7:0]). CHAN_ORDER = 1 sends inData[23:0] as it stands. Within each channel the most significant bit goes first.
- R5: Each LED occupies exactly 72 slots. The first slot of the next LED directly follows the last slot of the current one, with no gap.
- R6: inReady is high while the block is idle. While sending, inReady is high only during the final clock of the last slot of an LED that is not flagged last, and low at all other times. A word is taken on a clock edge where inValid and inReady are both high.
- R7: After the LED flagged as last, dataOut stays low for LATCH_SLOTS*DIV clocks with busy high. busy then falls.
- R8: If no valid word is offered when a non-last LED ends, the block enters the same low latch interval as in R7 (underrun).
- R9: When idle, dataOut is low, busy is low, and inData and inLast have no effect while inValid is low.
- R10: A synchronous reset drives dataOut and busy low on the next clock, even in the middle of a frame. Afterwards the block accepts a new frame normally.
- R11: On the clock after a word is accepted from idle, busy is high and dataOut is high (the first slot of the first symbol).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Colour word offered |
| inData | input | 24 | Colour word: red 23:16, green 15:8, blue 7:0 |
| inLast | input | 1 | Offered word is the last LED of the frame |
| inReady | output | 1 | Block takes the offered word on this edge |
| dataOut | output | 1 | Serial LED data line, idles low |
| busy | output | 1 | Frame or latch interval in progress |

## Verification
A word accepted from idle makes dataOut and busy high one clock later. From that point, slot k of the frame occupies clocks k*DIV to k*DIV+DIV-1, and the latch interval follows the final slot directly. The bench samples dataOut on the falling edge of every clock while busy is high. It then cuts the captured trace into 3*DIV windows at those exact offsets and measures the high and low run of each window in clocks. It also checks the total trace length, which fixes both the gapless chaining and the latch length. Reset and ready checks are sampled on the falling edge one clock after the edge that should cause them.

// File: rtl/ledenc_pkg.sv
package ledenc_pkg;
  localparam int SLOTS_PER_BIT = 3;
  localparam int BITS_PER_LED  = 24;
  localparam int SLOTS_PER_LED = SLOTS_PER_BIT * BITS_PER_LED;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_LATCH = 2'd2
  } encState_t;

  typedef struct packed {
    logic load;   // take a new encoded LED word
    logic shift;  // advance one slot
    logic clear;  // drop to low line (latch)
  } slotCtrl_t;
endpackage

// File: rtl/ledenc_ctrl.sv
module ledenc_ctrl
  import ledenc_pkg::*;
#(
  parameter int DIV         = 32,
  parameter int LATCH_SLOTS = 120
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  output logic      inReady,
  output logic      busy,
  output slotCtrl_t ctrl
);
  localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SLOT_W = $clog2(SLOTS_PER_LED);
  localparam int LAT_W  = (LATCH_SLOTS > 1) ? $clog2(LATCH_SLOTS) : 1;

  encState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [LAT_W-1:0]  latchCnt;
  logic              curLast;

  logic slotEnd, lastSlot, ledEnd, latchDone, accept;

  assign slotEnd   = (divCnt == DIV_W'(DIV - 1));
  assign lastSlot  = (slotCnt == SLOT_W'(SLOTS_PER_LED - 1));
  assign latchDone = (latchCnt == LAT_W'(LATCH_SLOTS - 1));
  assign ledEnd    = (state == ST_SEND) && slotEnd && lastSlot;

  assign inReady = (state == ST_IDLE) || (ledEnd && !curLast);
  assign accept  = inValid && inReady;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    ctrl.load  = accept;
    ctrl.shift = (state == ST_SEND) && slotEnd && !lastSlot;
    ctrl.clear = ledEnd && !accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      slotCnt  <= '0;
      latchCnt <= '0;
      curLast  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          divCnt <= '0;
          if (accept) begin
            state   <= ST_SEND;
            slotCnt <= '0;
            curLast <= inLast;
          end
        end
        ST_SEND: begin
          divCnt <= slotEnd ? '0 : divCnt + 1'b1;
          if (slotEnd) begin
            if (!lastSlot) begin
              slotCnt <= slotCnt + 1'b1;
            end else if (accept) begin
              slotCnt <= '0;
              curLast <= inLast;
            end else begin
              state    <= ST_LATCH;
              slotCnt  <= '0;
              latchCnt <= '0;
            end
          end
        end
        ST_LATCH: begin
          divCnt <= slotEnd ? '0 : divCnt + 1'b1;
          if (slotEnd) begin
            if (latchDone) begin
              state    <= ST_IDLE;
              latchCnt <= '0;
            end else begin
              latchCnt <= latchCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ledenc_dp.sv
module ledenc_dp
  import ledenc_pkg::*;
#(
  parameter int         CHAN_ORDER = 0,
  parameter logic [2:0] PAT_ONE    = 3'b110,
  parameter logic [2:0] PAT_ZERO   = 3'b100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] colour,
  input  slotCtrl_t   ctrl,
  output logic        dataOut
);
  logic [BITS_PER_LED-1:0]  wireWord;
  logic [SLOTS_PER_LED-1:0] encoded;
  logic [SLOTS_PER_LED-1:0] slotReg;

  generate
    if (CHAN_ORDER == 0) begin : g_grb
      assign wireWord = {colour[15:8], colour[23:16], colour[7:0]};
    end else begin : g_rgb
      assign wireWord = colour;
    end
  endgenerate

  always_comb begin
    encoded = '0;
    for (int i = 0; i < BITS_PER_LED; i++) begin
      encoded[SLOTS_PER_LED-1-SLOTS_PER_BIT*i -: SLOTS_PER_BIT] =
        wireWord[BITS_PER_LED-1-i] ? PAT_ONE : PAT_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      slotReg <= '0;
    end else if (ctrl.load) begin
      slotReg <= encoded;
    end else if (ctrl.shift) begin
      slotReg <= {slotReg[SLOTS_PER_LED-2:0], 1'b0};
    end
  end

  assign dataOut = slotReg[SLOTS_PER_LED-1];
endmodule

// File: rtl/ledenc_top.sv
module ledenc_top
  import ledenc_pkg::*;
#(
  parameter int         DIV         = 32,
  parameter int         LATCH_SLOTS = 120,
  parameter int         CHAN_ORDER  = 0,
  parameter logic [2:0] PAT_ONE     = 3'b110,
  parameter logic [2:0] PAT_ZERO    = 3'b100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [23:0] inData,
  input  logic        inLast,
  output logic        inReady,
  output logic        dataOut,
  output logic        busy
);
  slotCtrl_t ctrl;

  ledenc_ctrl #(.DIV(DIV), .LATCH_SLOTS(LATCH_SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .busy(busy), .ctrl(ctrl)
  );

  ledenc_dp #(.CHAN_ORDER(CHAN_ORDER), .PAT_ONE(PAT_ONE), .PAT_ZERO(PAT_ZERO)) u_dp (
    .clk(clk), .rst(rst), .colour(inData), .ctrl(ctrl), .dataOut(dataOut)
  );
endmodule

// File: rtl/ledenc_chk.sv
module ledenc_chk #(
  parameter int DIV = 32
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inReady,
  input logic busy,
  input logic dataOut
);
  localparam int RUN_W = $clog2(2 * DIV + 2);
  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (rst) hiRun <= '0;
    else if (!dataOut) hiRun <= '0;
    else if (hiRun != RUN_W'(2 * DIV + 1)) hiRun <= hiRun + 1'b1;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !busy |-> !dataOut); // R9
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst) !busy |-> inReady); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst) (inValid && inReady && !busy) |=> (busy && dataOut)); // R11
  AST_HIGH_RUN_MAX: assert property (@(posedge clk) disable iff (rst) dataOut |-> (hiRun < RUN_W'(2 * DIV))); // R1
  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> !$past(dataOut)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!busy && !dataOut)); // R10
endmodule

bind ledenc_top ledenc_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .busy(busy), .dataOut(dataOut)
);

// File: tb/ledenc_top_tb.sv
module ledenc_top_tb;
  localparam int DIV = 4;
  localparam int LS  = 6;
  localparam int SYM = 3 * DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [23:0] inData = '0;
  logic        inLast = 1'b0;
  logic        inReady, dataOut, busy;

  int checks = 0;
  int errors = 0;
  logic cap[$];
  logic [23:0] frameCol[$];

  // {last, colour}
  localparam logic [24:0] VEC [0:6] = '{
    25'h0FF0000, 25'h000FF00, 25'h10000FF,
    25'h1A53C81,
    25'h0800001, 25'h17FFFFE,
    25'h1FFFFFF
  };

  always #10 clk = ~clk;

  ledenc_top #(.DIV(DIV), .LATCH_SLOTS(LS)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .dataOut(dataOut), .busy(busy)
  );

  always @(negedge clk) if (busy) cap.push_back(dataOut);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [23:0] c, input logic last);
    frameCol.push_back(c);
    inValid = 1'b1; inData = c; inLast = last;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inData = 24'h5A5A5A;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic checkFrame();
    int n = frameCol.size();
    int body = n * 24 * SYM;
    int tailOk = 1;
    check(cap.size() == body + LS * DIV, "R5/R7 frame length", cap.size(), body + LS * DIV);
    for (int j = 0; j < n; j++) begin
      logic [23:0] c = frameCol[j];
      logic [23:0] w = {c[15:8], c[23:16], c[7:0]};
      for (int b = 0; b < 24; b++) begin
        int p = (j * 24 + b) * SYM;
        int h = 0;
        int l = 0;
        int expH = w[23-b] ? 2 * DIV : DIV;
        if (p + SYM <= cap.size()) begin
          while (h < SYM && cap[p+h] == 1'b1) h++;
          for (int k = h; k < SYM; k++) if (cap[p+k] == 1'b0) l++;
        end
        check(h == expH && l == SYM - expH,
              w[23-b] ? "R1/R3/R4 one-bit high time" : "R2/R3/R4 zero-bit high time",
              h * 1000 + l, expH * 1000 + (SYM - expH));
      end
    end
    for (int k = body; k < cap.size(); k++) if (cap[k] != 1'b0) tailOk = 0;
    check(tailOk == 1, "R7 latch line low", tailOk, 1);
    check(!busy && inReady, "R7 busy released", {30'd0, busy, inReady}, 1);
    cap.delete();
    frameCol.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!dataOut && !busy && inReady, "R10 reset state", {29'd0, dataOut, busy, inReady}, 1);

    // R9: data and last with valid low are ignored
    inData = 24'hFFFFFF; inLast = 1'b1;
    repeat (10) @(negedge clk);
    check(!dataOut && !busy && cap.size() == 0, "R9 idle ignores inputs", {30'd0, dataOut, busy}, 0);

    // table of frames
    for (int i = 0; i < 7; i++) begin
      sendWord(VEC[i][23:0], VEC[i][24]);
      if (VEC[i][24]) begin
        waitIdle();
        checkFrame();
      end
    end

    // R6 and R11: ready low mid-LED, first slot high
    inValid = 1'b1; inData = 24'h0F0F0F; inLast = 1'b0;
    frameCol.push_back(24'h0F0F0F);
    @(negedge clk);
    inValid = 1'b0;
    check(busy && dataOut, "R11 first slot after accept", {30'd0, busy, dataOut}, 3);
    repeat (5) @(negedge clk);
    check(!inReady && busy, "R6 ready low mid-LED", inReady, 0);
    sendWord(24'hC30081, 1'b1);
    waitIdle();
    checkFrame();

    // R8: underrun after non-last LED
    sendWord(24'h123456, 1'b0);
    waitIdle();
    check(cap.size() == 24 * SYM + LS * DIV, "R8 underrun goes to latch", cap.size(), 24 * SYM + LS * DIV);
    checkFrame();

    // R10: reset mid-frame
    sendWord(24'hFFFFFF, 1'b0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!dataOut && !busy, "R10 reset mid-frame", {30'd0, dataOut, busy}, 0);
    @(negedge clk);
    rst = 1'b0;
    cap.delete();
    frameCol.delete();
    @(negedge clk);
    sendWord(24'h00AA55, 1'b1);
    waitIdle();
    checkFrame();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule